// File: doc/BRIEF.md
# Ring Gate Call Unit

This unit carries out a call from one protection ring into a more privileged ring. A caller names a target segment and a gate number within it, together with the address to return to. The unit reads the target segment's descriptor, which gives the number of gates the segment exports, the ring the segment runs in, and the outermost ring allowed to call it. It checks the call against those three fields. A call that fails any check raises a one-cycle gate-violation fault and leaves all architectural state as it was.

A call that passes reads one word from the gate table, which sits at the start of the segment with one entry offset per gate in gate order. The unit adds the segment's physical base to that offset to form the new program counter. In the same cycle it records the return address and the caller's ring, and it moves the current ring inward to the segment's execution ring. The sequence runs through a small controller. `busy` is high from the cycle after the request is taken until the commit or fault cycle.

Top module: `ring_gate_call`

## Requirements
- R1: After synchronous reset, `cur_ring` equals RESET_RING (default 7), and `pc`, `ret_pc` and `ret_ring` are 0. `busy`, `fault`, `done` and `mem_req` are all low.
- R2: A call whose gate number is not strictly less than the descriptor's gate count ends in `fault`. A gate count of 0 means no gate can be called.
- R3: A call is legal only if the descriptor's execution ring is strictly less than `cur_ring` and `cur_ring` is no greater than the descriptor's call bracket. Any other call ends in `fault`.
- R4: A faulting call leaves `pc`, `cur_ring`, `ret_pc` and `ret_ring` unchanged and makes no memory read.
- R5: A legal call raises `mem_req` with `mem_addr` = segment base + gate number. Both are held steady until `mem_valid` is seen.
- R6: On commit, `pc` becomes the segment base plus the word returned by the gate read.
- R7: On commit, `ret_pc` takes the request's return address, `ret_ring` takes the ring in force before the call, and `cur_ring` takes the descriptor's execution ring.
- R8: `busy` rises in the cycle after a request is accepted and stays high until the unit returns to idle. `call_valid` has no effect while `busy` is high.
- R9: With the call bracket equal to the execution ring plus one, only the ring directly above the execution ring may call. A caller one ring further out faults.
- R10: `done` and `fault` are single-cycle pulses and never high together. Each call produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_valid | input | 1 | Call request, taken when idle |
| call_seg | input | SEG_W | Target segment index |
| call_gate | input | GATE_W | Gate number within the segment |
| call_ret_pc | input | ADDR_W | Return address to record |
| desc_idx | output | SEG_W | Segment index for descriptor lookup |
| desc_base | input | ADDR_W | Physical base of the looked-up segment |
| desc_ngates | input | GATE_W+1 | Number of gates the segment exports |
| desc_xring | input | RING_W | Execution ring of the segment |
| desc_cbrk | input | RING_W | Outermost ring allowed to call |
| mem_req | output | 1 | Gate word read request |
| mem_addr | output | ADDR_W | Gate word address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | ADDR_W | Read data (entry offset) |
| busy | output | 1 | Call in progress |
| pc | output | ADDR_W | Program counter after the last legal call |
| cur_ring | output | RING_W | Current ring |
| ret_pc | output | ADDR_W | Saved return address |
| ret_ring | output | RING_W | Saved caller ring |
| fault | output | 1 | Gate-violation pulse |
| done | output | 1 | Commit pulse |

## Verification
The embedded properties check several things on every cycle. On a fault pulse, all four architectural registers hold their values. A held gate read keeps its address. Each commit moves the ring strictly inward and saves the previous ring. `done` and `fault` never coincide, and neither lasts more than one cycle. Only the directed scenarios can show the arithmetic that the properties do not model: each individual bracket boundary, the zero gate count, the exact relocated entry address, and that a request arriving during a long gate read is dropped.

// File: rtl/rgc_pkg.sv
package rgc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_READ   = 2'd2,
        ST_COMMIT = 2'd3
    } rgc_state_e;

    typedef enum logic [1:0] {
        VD_PASS     = 2'd0,
        VD_BAD_GATE = 2'd1,
        VD_BAD_RING = 2'd2
    } rgc_verdict_e;

    // caller ring must sit outside the execution ring and inside the call bracket
    function automatic logic ring_in_window(input int unsigned caller,
                                            input int unsigned exec_ring,
                                            input int unsigned bracket);
        return (exec_ring < caller) && (caller <= bracket);
    endfunction

endpackage

// File: rtl/rgc_gate_check.sv
module rgc_gate_check
    import rgc_pkg::*;
#(
    parameter int RING_W = 3,
    parameter int GATE_W = 4
) (
    input  logic [GATE_W-1:0] gate,
    input  logic [GATE_W:0]   ngates,
    input  logic [RING_W-1:0] caller_ring,
    input  logic [RING_W-1:0] exec_ring,
    input  logic [RING_W-1:0] bracket,
    output rgc_verdict_e      verdict,
    output logic              legal
);
    localparam int NG_W = GATE_W + 1;

    logic gate_ok;
    logic ring_ok;

    assign gate_ok = {1'b0, gate} < ngates[NG_W-1:0];
    assign ring_ok = ring_in_window(int'(caller_ring), int'(exec_ring), int'(bracket));

    always_comb begin
        if (!gate_ok)      verdict = VD_BAD_GATE;
        else if (!ring_ok) verdict = VD_BAD_RING;
        else               verdict = VD_PASS;
    end

    assign legal = (verdict == VD_PASS);

    always_comb begin
        if (legal) assert (exec_ring < caller_ring)
            else $error("p_legal_inward_r3: pass with non-inward ring");
    end
endmodule

// File: rtl/rgc_ctrl.sv
module rgc_ctrl
    import rgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       call_valid,
    input  logic       legal,
    input  logic       mem_valid,
    output rgc_state_e state,
    output logic       accept,
    output logic       in_check,
    output logic       rd_done,
    output logic       in_commit,
    output logic       in_read
);
    rgc_state_e nxt;

    assign accept    = (state == ST_IDLE) && call_valid;
    assign in_check  = (state == ST_CHECK);
    assign in_read   = (state == ST_READ);
    assign rd_done   = in_read && mem_valid;
    assign in_commit = (state == ST_COMMIT);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (call_valid) nxt = ST_CHECK;
            ST_CHECK:  nxt = legal ? ST_READ : ST_IDLE;
            ST_READ:   if (mem_valid) nxt = ST_COMMIT;
            ST_COMMIT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !call_valid) |=> (state == ST_IDLE));

    p_check_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK) |=> (state != ST_CHECK));
endmodule

// File: rtl/rgc_ctx_regs.sv
module rgc_ctx_regs #(
    parameter int ADDR_W     = 16,
    parameter int RING_W     = 3,
    parameter int RESET_RING = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [ADDR_W-1:0] new_pc,
    input  logic [RING_W-1:0] new_ring,
    input  logic [ADDR_W-1:0] link_pc,
    output logic [ADDR_W-1:0] pc,
    output logic [RING_W-1:0] cur_ring,
    output logic [ADDR_W-1:0] ret_pc,
    output logic [RING_W-1:0] ret_ring
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            cur_ring <= RING_W'(RESET_RING);
            ret_pc   <= '0;
            ret_ring <= '0;
        end else if (commit) begin
            pc       <= new_pc;
            ret_pc   <= link_pc;
            ret_ring <= cur_ring;
            cur_ring <= new_ring;
        end
    end

    p_ctx_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(pc) && $stable(cur_ring) && $stable(ret_pc) && $stable(ret_ring)));
endmodule

// File: rtl/ring_gate_call.sv
module ring_gate_call
    import rgc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int RING_W     = 3,
    parameter int SEG_W      = 3,
    parameter int GATE_W     = 4,
    parameter int RESET_RING = (1 << RING_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_valid,
    input  logic [SEG_W-1:0]  call_seg,
    input  logic [GATE_W-1:0] call_gate,
    input  logic [ADDR_W-1:0] call_ret_pc,
    output logic [SEG_W-1:0]  desc_idx,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [GATE_W:0]   desc_ngates,
    input  logic [RING_W-1:0] desc_xring,
    input  logic [RING_W-1:0] desc_cbrk,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] pc,
    output logic [RING_W-1:0] cur_ring,
    output logic [ADDR_W-1:0] ret_pc,
    output logic [RING_W-1:0] ret_ring,
    output logic              fault,
    output logic              done
);
    localparam int GPAD = ADDR_W - GATE_W;

    rgc_state_e   state;
    rgc_verdict_e verdict;
    logic accept, in_check, rd_done, in_commit, in_read, legal;

    logic [SEG_W-1:0]  seg_q;
    logic [GATE_W-1:0] gate_q;
    logic [ADDR_W-1:0] link_q;
    logic [ADDR_W-1:0] base_q;
    logic [RING_W-1:0] xring_q;
    logic [ADDR_W-1:0] entry_q;
    logic [ADDR_W-1:0] gate_addr;
    logic [ADDR_W-1:0] target_pc;
    logic fault_q, done_q;

    rgc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .call_valid(call_valid), .legal(legal),
        .mem_valid(mem_valid), .state(state), .accept(accept),
        .in_check(in_check), .rd_done(rd_done), .in_commit(in_commit),
        .in_read(in_read)
    );

    rgc_gate_check #(.RING_W(RING_W), .GATE_W(GATE_W)) u_check (
        .gate(gate_q), .ngates(desc_ngates), .caller_ring(cur_ring),
        .exec_ring(desc_xring), .bracket(desc_cbrk),
        .verdict(verdict), .legal(legal)
    );

    rgc_ctx_regs #(.ADDR_W(ADDR_W), .RING_W(RING_W), .RESET_RING(RESET_RING)) u_ctx (
        .clk(clk), .rst(rst), .commit(in_commit), .new_pc(target_pc),
        .new_ring(xring_q), .link_pc(link_q), .pc(pc), .cur_ring(cur_ring),
        .ret_pc(ret_pc), .ret_ring(ret_ring)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q   <= '0;
            gate_q  <= '0;
            link_q  <= '0;
            base_q  <= '0;
            xring_q <= '0;
            entry_q <= '0;
            fault_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (accept) begin
                seg_q  <= call_seg;
                gate_q <= call_gate;
                link_q <= call_ret_pc;
            end
            if (in_check) begin
                base_q  <= desc_base;
                xring_q <= desc_xring;
            end
            if (rd_done) entry_q <= mem_rdata;
            fault_q <= in_check && !legal;
            done_q  <= in_commit;
        end
    end

    assign desc_idx  = seg_q;
    assign gate_addr = base_q + {{GPAD{1'b0}}, gate_q};
    assign target_pc = base_q + entry_q;
    assign mem_req   = in_read;
    assign mem_addr  = gate_addr;
    assign busy      = (state != ST_IDLE);
    assign fault     = fault_q;
    assign done      = done_q;

    p_fault_keeps_state_r4: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($stable(pc) && $stable(cur_ring) && $stable(ret_pc) && $stable(ret_ring)));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_ring_inward_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (cur_ring < ret_ring));

    p_ret_ring_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (ret_ring == $past(cur_ring)));

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    p_fault_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);

    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(call_valid));
endmodule

// File: tb/sim_ring_gate_call.sv
module sim_ring_gate_call;
    localparam int AW = 16, RW = 3, SW = 3, GW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, call_valid, mem_req, mem_valid, busy, fault, done;
    logic [SW-1:0] call_seg, desc_idx;
    logic [GW-1:0] call_gate;
    logic [AW-1:0] call_ret_pc, desc_base, mem_addr, mem_rdata, pc, ret_pc;
    logic [GW:0]   desc_ngates;
    logic [RW-1:0] desc_xring, desc_cbrk, cur_ring, ret_ring;

    ring_gate_call u0 (.*);

    logic [AW-1:0] t_base [8];
    logic [GW:0]   t_ng   [8];
    logic [RW-1:0] t_xr   [8];
    logic [RW-1:0] t_cb   [8];

    always_comb begin
        desc_base   = t_base[desc_idx];
        desc_ngates = t_ng[desc_idx];
        desc_xring  = t_xr[desc_idx];
        desc_cbrk   = t_cb[desc_idx];
    end

    function automatic logic [AW-1:0] entry_of(input logic [AW-1:0] a);
        return ((a << 1) ^ 16'h0135) & 16'h03FF;
    endfunction

    int errors = 0, checks = 0;
    int lat = 0, wait_cnt = 0, reads = 0;
    logic [AW-1:0] last_addr;

    // gate table memory with programmable latency
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = entry_of(mem_addr);
                last_addr = mem_addr;
                reads++;
            end else begin
                mem_valid = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_valid = 1'b0;
            wait_cnt  = 0;
        end
    end

    logic [AW-1:0] e_pc = '0, e_rpc = '0;
    logic [RW-1:0] e_ring = 3'd7, e_rring = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ctx(input string req);
        chk({req, " pc"}, 32'(pc), 32'(e_pc));
        chk({req, " cur_ring"}, 32'(cur_ring), 32'(e_ring));
        chk({req, " ret_pc"}, 32'(ret_pc), 32'(e_rpc));
        chk({req, " ret_ring"}, 32'(ret_ring), 32'(e_rring));
    endtask

    task automatic run_call(input logic [SW-1:0] s, input logic [GW-1:0] g,
                            input logic [AW-1:0] rpc, output logic got_fault);
        int n = 0;
        @(negedge clk);
        call_valid = 1'b1; call_seg = s; call_gate = g; call_ret_pc = rpc;
        @(negedge clk);
        call_valid = 1'b0;
        chk("R8 busy after accept", 32'(busy), 32'd1);
        while (!done && !fault && n < 60) begin
            @(negedge clk);
            n++;
        end
        got_fault = fault;
        chk("R10 one outcome", 32'(done ^ fault), 32'd1);
        @(negedge clk);
        chk("R10 pulse ends", 32'({done, fault}), 32'd0);
    endtask

    task automatic expect_legal(input string req, input logic [SW-1:0] s,
                                input logic [GW-1:0] g, input logic [AW-1:0] rpc);
        logic f;
        logic [AW-1:0] ga;
        run_call(s, g, rpc, f);
        ga = t_base[s] + AW'(g);
        chk({req, " legal"}, 32'(f), 32'd0);
        chk("R5 gate address", 32'(last_addr), 32'(ga));
        e_pc = t_base[s] + entry_of(ga);
        e_rpc = rpc; e_rring = e_ring; e_ring = t_xr[s];
        chk_ctx({req, " R6 R7 commit"});
    endtask

    task automatic expect_fault(input string req, input logic [SW-1:0] s, input logic [GW-1:0] g);
        logic f;
        int r0 = reads;
        run_call(s, g, 16'hDEAD, f);
        chk({req, " fault"}, 32'(f), 32'd1);
        chk("R4 no read on fault", 32'(reads), 32'(r0));
        chk_ctx("R4 state kept");
    endtask

    task automatic t_reset;
        chk("R1 cur_ring", 32'(cur_ring), 32'd7);
        chk("R1 pc", 32'(pc), 32'd0);
        chk("R1 ret", 32'({ret_pc, ret_ring}), 32'd0);
        chk("R1 flags", 32'({busy, fault, done, mem_req}), 32'd0);
    endtask

    task automatic t_busy_ignore;
        int n = 0;
        logic [AW-1:0] ga;
        lat = 6;
        @(negedge clk);
        call_valid = 1'b1; call_seg = 3'd1; call_gate = 4'd1; call_ret_pc = 16'h4444;
        @(negedge clk);
        call_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 busy during read", 32'(busy), 32'd1);
        call_valid = 1'b1; call_seg = 3'd5; call_gate = 4'd0; call_ret_pc = 16'h9999;
        @(negedge clk);
        call_valid = 1'b0;
        while (!done && !fault && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk("R8 first call completes", 32'(done), 32'd1);
        ga = t_base[1] + 16'd1;
        e_pc = t_base[1] + entry_of(ga); e_rpc = 16'h4444; e_rring = e_ring; e_ring = t_xr[1];
        repeat (4) @(negedge clk);
        chk("R8 ignored call left idle", 32'({busy, fault, done}), 32'd0);
        chk_ctx("R8 ignored call no effect");
        lat = 0;
    endtask

    initial begin
        t_base[0] = 16'h0200; t_ng[0] = 5'd4;  t_xr[0] = 3'd3; t_cb[0] = 3'd7;
        t_base[1] = 16'h0400; t_ng[1] = 5'd2;  t_xr[1] = 3'd1; t_cb[1] = 3'd3;
        t_base[2] = 16'h0600; t_ng[2] = 5'd8;  t_xr[2] = 3'd2; t_cb[2] = 3'd3;
        t_base[3] = 16'h0800; t_ng[3] = 5'd0;  t_xr[3] = 3'd0; t_cb[3] = 3'd7;
        t_base[4] = 16'h0A00; t_ng[4] = 5'd3;  t_xr[4] = 3'd0; t_cb[4] = 3'd1;
        t_base[5] = 16'h0C00; t_ng[5] = 5'd16; t_xr[5] = 3'd0; t_cb[5] = 3'd2;
        t_base[6] = 16'h0E00; t_ng[6] = 5'd1;  t_xr[6] = 3'd0; t_cb[6] = 3'd0;
        t_base[7] = 16'h1000; t_ng[7] = 5'd1;  t_xr[7] = 3'd0; t_cb[7] = 3'd0;
        rst = 1'b1; call_valid = 1'b0; call_seg = '0; call_gate = '0; call_ret_pc = '0;
        mem_valid = 1'b0; mem_rdata = '0; last_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        lat = 2;
        expect_legal("R3 ring7 to xr3", 3'd0, 4'd3, 16'h1234);
        expect_fault("R2 gate equals count", 3'd1, 4'd2);
        expect_fault("R2 zero gate count", 3'd3, 4'd0);
        expect_fault("R3 caller equals exec ring", 3'd0, 4'd0);
        expect_fault("R3 caller beyond bracket", 3'd5, 4'd0);
        lat = 0;
        expect_legal("R9 adjacent ring", 3'd2, 4'd7, 16'h2468);
        expect_fault("R9 one ring too far", 3'd4, 4'd0);
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule